// File: doc/BRIEF.md
# Accumulator Processor Bus Datapath

This block is the register-transfer datapath of a small accumulator machine. Seven registers of mixed width (a 16-bit accumulator, memory buffer and instruction register; a 12-bit address register and program counter; 8-bit input and output registers) and a word-addressed memory of 4096 sixteen-bit locations all hang off one shared 16-bit bus. A 3-bit source code picks the single device that drives the bus, and one-hot load enables pick the registers that capture it on the rising clock edge.

Alongside the bus, dedicated side paths feed the accumulator and the memory buffer into the ALU, and carry the ALU result back into the accumulator. An ALU update therefore never occupies the bus, and it can run in the same cycle as an unrelated bus transfer. A four-bit flag register records the outcome of each ALU write. Instruction decoding and sequencing live elsewhere: every control signal arrives as an input. The address register drives the memory address directly. Memory writes take the memory buffer as their data.

Top module: `acc_datapath`

## Requirements
- R1: While reset is held, and right after it is released, the accumulator, memory buffer, instruction register, address register, program counter, output register and flags all read zero.
- R2: bus_sel encodes the bus source as 0 = nothing (bus reads 0x0000), 1 = address register, 2 = program counter, 3 = memory buffer, 4 = accumulator, 5 = input register, 6 = output register, 7 = memory read data. The 12-bit and 8-bit sources are zero-extended to 16 bits.
- R3: A register whose load enable (ld_mar, ld_mbr, ld_ir, ld_out) is high takes the bus value at the rising edge. A 12-bit register keeps bits 11:0 and an 8-bit register keeps bits 7:0. A register whose enable is low keeps its value.
- R4: ld_pc loads the program counter from bus bits 11:0. Otherwise pc_inc adds one, wrapping from 0xFFF to 0x000. ld_pc wins over pc_inc.
- R5: mem_we writes the memory buffer into the location held by the address register at the rising edge. Memory reads are synchronous: bus source 7 carries the word that was stored at the address-register value of the previous cycle. All 4096 addresses, 0x000 through 0xFFF, are usable.
- R6: With alu_en high, the accumulator loads the ALU result through the side path. alu_op encodes the operation as 0 = pass memory buffer, 1 = accumulator + memory buffer, 2 = accumulator − memory buffer, 3 = pass accumulator. alu_en wins over ld_ac. With alu_en low and ld_ac high, the accumulator loads the bus.
- R7: flags = {Z, N, C, V}, with Z in bit 3 and V in bit 0. They update only on an ALU write. Z is set when the result is zero and N is the result's bit 15. For add, C is the carry out and V is signed overflow. For subtract, C is the borrow (the accumulator is below the memory buffer as unsigned values) and V is signed overflow. For both pass operations, C and V are 0.
- R8: An ALU write and a bus transfer in the same cycle both take effect, and both use the register values from before that edge.
- R9: ld_in samples in_data into the input register, and out_data always shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| ld_mar | input | 1 | Load address register from bus |
| ld_pc | input | 1 | Load program counter from bus |
| pc_inc | input | 1 | Increment program counter |
| ld_mbr | input | 1 | Load memory buffer from bus |
| ld_ac | input | 1 | Load accumulator from bus |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_out | input | 1 | Load output register from bus |
| ld_in | input | 1 | Sample in_data into input register |
| mem_we | input | 1 | Write memory buffer to memory |
| alu_en | input | 1 | Write ALU result to accumulator and update flags |
| alu_op | input | 2 | ALU operation code |
| in_data | input | 8 | External input device data |
| out_data | output | 8 | Output register contents |
| bus_val | output | 16 | Current value on the shared bus |
| ac_q | output | 16 | Accumulator |
| mbr_q | output | 16 | Memory buffer |
| ir_q | output | 16 | Instruction register |
| mar_q | output | 12 | Memory address register |
| pc_q | output | 12 | Program counter |
| flags | output | 4 | {Z, N, C, V} |

## Verification
The case that matters most is an accumulator update through the ALU side path in the same cycle as a bus transfer that reads the accumulator, or that targets it through ld_ac. The bench raises alu_en together with a bus copy of the accumulator into the output register. It expects the output register to receive the old accumulator value while the accumulator takes the sum. It then asserts ld_ac and alu_en together and expects the ALU result, not the bus value, in the accumulator. A further case moves the input register to the output register over the bus while the memory buffer reaches the accumulator through its dedicated path.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int IO_W   = 8;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_MAR  = 3'd1,
    SRC_PC   = 3'd2,
    SRC_MBR  = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IN   = 3'd5,
    SRC_OUT  = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  typedef enum logic [1:0] {
    ALU_PASS_B = 2'd0,
    ALU_ADD    = 2'd1,
    ALU_SUB    = 2'd2,
    ALU_PASS_A = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_dp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output flags_t       fl
);
  logic [W:0] sum_w;
  logic [W:0] dif_w;

  always_comb begin
    sum_w = {1'b0, a} + {1'b0, b};
    dif_w = {1'b0, a} - {1'b0, b};
    res   = b;
    fl.c  = 1'b0;
    fl.v  = 1'b0;
    unique case (op)
      ALU_ADD: begin
        res  = sum_w[W-1:0];
        fl.c = sum_w[W];
        fl.v = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        res  = dif_w[W-1:0];
        fl.c = dif_w[W];
        fl.v = (a[W-1] != b[W-1]) && (dif_w[W-1] != a[W-1]);
      end
      ALU_PASS_A: res = a;
      default:    res = b;
    endcase
    fl.z = (res == '0);
    fl.n = res[W-1];
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux
  import acc_dp_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int IOW = 8
) (
  input  bus_src_e       sel,
  input  logic [AW-1:0]  mar,
  input  logic [AW-1:0]  pc,
  input  logic [DW-1:0]  mbr,
  input  logic [DW-1:0]  ac,
  input  logic [IOW-1:0] inr,
  input  logic [IOW-1:0] outr,
  input  logic [DW-1:0]  mem,
  output logic [DW-1:0]  bus
);
  localparam int APAD = DW - AW;
  localparam int IPAD = DW - IOW;

  always_comb begin
    unique case (sel)
      SRC_MAR: bus = {{APAD{1'b0}}, mar};
      SRC_PC:  bus = {{APAD{1'b0}}, pc};
      SRC_MBR: bus = mbr;
      SRC_AC:  bus = ac;
      SRC_IN:  bus = {{IPAD{1'b0}}, inr};
      SRC_OUT: bus = {{IPAD{1'b0}}, outr};
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int DW  = acc_dp_pkg::DATA_W,
  parameter int AW  = acc_dp_pkg::ADDR_W,
  parameter int IOW = acc_dp_pkg::IO_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     bus_sel,
  input  logic           ld_mar,
  input  logic           ld_pc,
  input  logic           pc_inc,
  input  logic           ld_mbr,
  input  logic           ld_ac,
  input  logic           ld_ir,
  input  logic           ld_out,
  input  logic           ld_in,
  input  logic           mem_we,
  input  logic           alu_en,
  input  logic [1:0]     alu_op,
  input  logic [IOW-1:0] in_data,
  output logic [IOW-1:0] out_data,
  output logic [DW-1:0]  bus_val,
  output logic [DW-1:0]  ac_q,
  output logic [DW-1:0]  mbr_q,
  output logic [DW-1:0]  ir_q,
  output logic [AW-1:0]  mar_q,
  output logic [AW-1:0]  pc_q,
  output logic [3:0]     flags
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [IOW-1:0] in_q;
  logic [DW-1:0]  mem_rd;
  logic [DW-1:0]  alu_res;
  flags_t         alu_fl;
  flags_t         fl_q;

  acc_bus_mux #(.DW(DW), .AW(AW), .IOW(IOW)) u_bus (
    .sel (bus_src_e'(bus_sel)),
    .mar (mar_q),
    .pc  (pc_q),
    .mbr (mbr_q),
    .ac  (ac_q),
    .inr (in_q),
    .outr(out_data),
    .mem (mem_rd),
    .bus (bus_val)
  );

  // plain bus-loaded registers
  acc_reg #(.W(AW)) u_mar (
    .clk(clk), .rst_n(rst_ni), .en(ld_mar), .d(bus_val[AW-1:0]), .q(mar_q));
  acc_reg #(.W(DW)) u_mbr (
    .clk(clk), .rst_n(rst_ni), .en(ld_mbr), .d(bus_val), .q(mbr_q));
  acc_reg #(.W(DW)) u_ir (
    .clk(clk), .rst_n(rst_ni), .en(ld_ir), .d(bus_val), .q(ir_q));
  acc_reg #(.W(IOW)) u_out (
    .clk(clk), .rst_n(rst_ni), .en(ld_out), .d(bus_val[IOW-1:0]), .q(out_data));
  acc_reg #(.W(IOW)) u_in (
    .clk(clk), .rst_n(rst_ni), .en(ld_in), .d(in_data), .q(in_q));

  acc_alu #(.W(DW)) u_alu (
    .a  (ac_q),
    .b  (mbr_q),
    .op (alu_op_e'(alu_op)),
    .res(alu_res),
    .fl (alu_fl)
  );

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (mar_q),
    .wdata(mbr_q),
    .rdata(mem_rd)
  );

  // accumulator, program counter and flags: next-state logic
  logic [DW-1:0] ac_d;
  logic          ac_en;
  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    ac_en = alu_en | ld_ac;
    ac_d  = alu_en ? alu_res : bus_val;
    pc_en = ld_pc | pc_inc;
    pc_d  = ld_pc ? bus_val[AW-1:0] : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      pc_q <= '0;
      fl_q <= '0;
    end else begin
      if (ac_en)  ac_q <= ac_d;
      if (pc_en)  pc_q <= pc_d;
      if (alu_en) fl_q <= alu_fl;
    end
  end

  assign flags = fl_q;
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int IOW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     bus_sel,
  input logic           ld_mar,
  input logic           ld_pc,
  input logic           pc_inc,
  input logic           ld_ac,
  input logic           ld_out,
  input logic           alu_en,
  input logic [IOW-1:0] out_data,
  input logic [DW-1:0]  bus_val,
  input logic [DW-1:0]  ac_q,
  input logic [AW-1:0]  mar_q,
  input logic [AW-1:0]  pc_q,
  input logic [3:0]     flags
);
  // R2
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd0) |-> (bus_val == '0));

  // R3
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> (mar_q == $past(bus_val[AW-1:0])));

  // R3
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mar |=> $stable(mar_q));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !ld_pc) |=> (pc_q == $past(pc_q) + 1'b1));

  // R6
  ac_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ac && !alu_en) |=> (ac_q == $past(bus_val)));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |=> (flags[3] == (ac_q == '0)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_en |=> $stable(flags));

  // R9
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out |=> (out_data == $past(bus_val[IOW-1:0])));
endmodule

bind acc_datapath acc_datapath_chk #(.DW(DW), .AW(AW), .IOW(IOW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ni),
  .bus_sel (bus_sel),
  .ld_mar  (ld_mar),
  .ld_pc   (ld_pc),
  .pc_inc  (pc_inc),
  .ld_ac   (ld_ac),
  .ld_out  (ld_out),
  .alu_en  (alu_en),
  .out_data(out_data),
  .bus_val (bus_val),
  .ac_q    (ac_q),
  .mar_q   (mar_q),
  .pc_q    (pc_q),
  .flags   (flags)
);

// File: tb/tb_acc_datapath.sv
module tb_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel;
  logic        ld_mar, ld_pc, pc_inc, ld_mbr, ld_ac, ld_ir, ld_out, ld_in;
  logic        mem_we, alu_en;
  logic [1:0]  alu_op;
  logic [7:0]  in_data;
  logic [7:0]  out_data;
  logic [15:0] bus_val, ac_q, mbr_q, ir_q;
  logic [11:0] mar_q, pc_q;
  logic [3:0]  flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_datapath dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ld_mar(ld_mar), .ld_pc(ld_pc),
    .pc_inc(pc_inc), .ld_mbr(ld_mbr), .ld_ac(ld_ac), .ld_ir(ld_ir), .ld_out(ld_out),
    .ld_in(ld_in), .mem_we(mem_we), .alu_en(alu_en), .alu_op(alu_op),
    .in_data(in_data), .out_data(out_data), .bus_val(bus_val), .ac_q(ac_q),
    .mbr_q(mbr_q), .ir_q(ir_q), .mar_q(mar_q), .pc_q(pc_q), .flags(flags)
  );

  // {ac, mbr, op, expected result, expected {Z,N,C,V}}
  localparam int NV = 9;
  localparam logic [53:0] VEC [NV] = '{
    {16'h0001, 16'h0002, 2'd1, 16'h0003, 4'b0000},
    {16'hFFFF, 16'h0001, 2'd1, 16'h0000, 4'b1010},
    {16'h7FFF, 16'h0001, 2'd1, 16'h8000, 4'b0101},
    {16'h8000, 16'h8000, 2'd1, 16'h0000, 4'b1011},
    {16'h0005, 16'h0005, 2'd2, 16'h0000, 4'b1000},
    {16'h0003, 16'h0005, 2'd2, 16'hFFFE, 4'b0110},
    {16'h8000, 16'h0001, 2'd2, 16'h7FFF, 4'b0001},
    {16'h1234, 16'h8001, 2'd0, 16'h8001, 4'b0100},
    {16'h0000, 16'h5555, 2'd3, 16'h0000, 4'b1000}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    bus_sel = 3'd0; ld_mar = 0; ld_pc = 0; pc_inc = 0; ld_mbr = 0; ld_ac = 0;
    ld_ir = 0; ld_out = 0; ld_in = 0; mem_we = 0; alu_en = 0; alu_op = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clr();
  endtask

  // build a 16-bit accumulator value from two input bytes (clobbers MBR, flags)
  task automatic load_ac(input logic [15:0] v);
    in_data = v[15:8]; ld_in = 1; tick();
    bus_sel = 3'd5; ld_mbr = 1; tick();
    alu_en = 1; alu_op = 2'd0; tick();
    for (int i = 0; i < 8; i++) begin
      bus_sel = 3'd4; ld_mbr = 1; tick();
      alu_en = 1; alu_op = 2'd1; tick();
    end
    in_data = v[7:0]; ld_in = 1; tick();
    bus_sel = 3'd5; ld_mbr = 1; tick();
    alu_en = 1; alu_op = 2'd1; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clr();
    in_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, while held
    chk("R1", "ac in reset", ac_q, 16'h0);
    chk("R1", "pc in reset", {4'h0, pc_q}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "ac", ac_q, 16'h0);
    chk("R1", "mbr", mbr_q, 16'h0);
    chk("R1", "ir", ir_q, 16'h0);
    chk("R1", "mar", {4'h0, mar_q}, 16'h0);
    chk("R1", "out", {8'h0, out_data}, 16'h0);
    chk("R1", "flags", {12'h0, flags}, 16'h0);
    chk("R2", "idle bus", bus_val, 16'h0);

    // vector table: operands staged through memory, then one ALU op (R5 R6 R7)
    for (int k = 0; k < NV; k++) begin
      load_ac(VEC[k][37:22]);
      bus_sel = 3'd4; ld_mbr = 1; tick();
      in_data = 8'(k); ld_in = 1; tick();
      bus_sel = 3'd5; ld_mar = 1; tick();
      mem_we = 1; tick();
      load_ac(VEC[k][53:38]);
      bus_sel = 3'd7; ld_mbr = 1; tick();
      chk("R5", "mbr from memory", mbr_q, VEC[k][37:22]);
      alu_en = 1; alu_op = VEC[k][21:20]; tick();
      chk("R6", "alu result", ac_q, VEC[k][19:4]);
      chk("R7", "flags", {12'h0, flags}, {12'h0, VEC[k][3:0]});
    end

    // R3 narrow loads keep low bits; R2 zero-extension
    load_ac(16'hABCD);
    bus_sel = 3'd4; ld_mar = 1; ld_out = 1; ld_ir = 1; ld_pc = 1; tick();
    chk("R3", "mar low bits", {4'h0, mar_q}, 16'h0BCD);
    chk("R3", "ir", ir_q, 16'hABCD);
    chk("R9", "out_data low bits", {8'h0, out_data}, 16'h00CD);
    bus_sel = 3'd1; #1 chk("R2", "mar on bus", bus_val, 16'h0BCD);
    bus_sel = 3'd2; #1 chk("R2", "pc on bus", bus_val, 16'h0BCD);
    bus_sel = 3'd6; #1 chk("R2", "out on bus", bus_val, 16'h00CD);
    bus_sel = 3'd0; #1 chk("R2", "none on bus", bus_val, 16'h0000);
    clr();
    tick();
    chk("R3", "mar held", {4'h0, mar_q}, 16'h0BCD);
    chk("R3", "ir held", ir_q, 16'hABCD);

    // R4 program counter priority and wrap
    load_ac(16'h0FFF);
    bus_sel = 3'd4; ld_pc = 1; pc_inc = 1; tick();
    chk("R4", "ld_pc over pc_inc", {4'h0, pc_q}, 16'h0FFF);
    pc_inc = 1; tick();
    chk("R4", "wrap to zero", {4'h0, pc_q}, 16'h0000);
    pc_inc = 1; tick();
    chk("R4", "increment", {4'h0, pc_q}, 16'h0001);

    // R5 top memory address
    load_ac(16'h0FFF);
    bus_sel = 3'd4; ld_mar = 1; tick();
    load_ac(16'h5A5A);
    bus_sel = 3'd4; ld_mbr = 1; tick();
    mem_we = 1; tick();
    load_ac(16'h0000);
    bus_sel = 3'd7; #1 chk("R5", "read at 0xFFF", bus_val, 16'h5A5A);
    ld_mbr = 1; tick();
    chk("R5", "mbr from 0xFFF", mbr_q, 16'h5A5A);

    // R8 concurrent bus transfer and ALU update
    load_ac(16'h0010);
    in_data = 8'h03; ld_in = 1; tick();
    bus_sel = 3'd5; #1 chk("R9", "input on bus", bus_val, 16'h0003);
    ld_mbr = 1; tick();
    bus_sel = 3'd4; ld_out = 1; alu_en = 1; alu_op = 2'd1; tick();
    chk("R8", "out took old ac", {8'h0, out_data}, 16'h0010);
    chk("R8", "ac took sum", ac_q, 16'h0013);
    bus_sel = 3'd5; ld_ac = 1; alu_en = 1; alu_op = 2'd3; tick();
    chk("R6", "alu_en over ld_ac", ac_q, 16'h0013);
    in_data = 8'h7E; ld_in = 1; tick();
    bus_sel = 3'd5; ld_out = 1; alu_en = 1; alu_op = 2'd0; tick();
    chk("R8", "out from input", {8'h0, out_data}, 16'h007E);
    chk("R8", "ac from mbr path", ac_q, 16'h0003);
    bus_sel = 3'd3; ld_ac = 1; tick();
    chk("R6", "ac from bus", ac_q, 16'h0003);
    chk("R7", "flags kept on bus load", {12'h0, flags}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule